// File: doc/BRIEF.md
# Command Reply Mailbox

This block is the controller side of a host command interface on a 32-bit memory-mapped register bus. The host posts a 32-bit command address by writing the request port; each accepted write enters a request FIFO that a local command engine drains through a valid/pop pair. When the engine finishes a command it pushes a tag, with an optional error flag, into a reply FIFO. The host collects tags by reading the reply port. One read both pops the FIFO and returns the tag, or returns an all-ones sentinel when nothing is waiting.

A status register shows a pending bit whenever replies are queued. A mask register with inverted sense gates the pending bit onto the host interrupt line: a set mask bit disables the interrupt and writing zero enables it. A parameter moves both the mask bit and the pending bit from bit 3 to bit 2. A doorbell register holds the last value the host wrote to it. A scratchpad reports readiness a set number of cycles after reset.

Top module: `cmd_mailbox`

## Requirements
- R1: A write to offset 0x40 while the request FIFO holds fewer than 16 entries appends the write data. The engine sees entries oldest first on `req_data_o`, with `req_valid_o` high while the FIFO is non-empty, and removes one entry per cycle with `req_pop_i`.
- R2: A write to offset 0x40 while the request FIFO holds 16 entries is discarded and sets `ovf_o`, which stays high until reset.
- R3: A read of offset 0x44 with replies queued returns the oldest reply and removes it. Replies come back in push order. `rpl_full_o` is high at 16 entries, and a push at that point is discarded.
- R4: A read of offset 0x44 with the reply FIFO empty returns 0xFFFFFFFF and leaves all state unchanged.
- R5: A reply pushed with `rpl_err_i` high is returned with bit 1 set, OR-ed into the pushed tag.
- R6: A read of offset 0x30 returns the pending bit (bit 3 by default), which is 1 exactly when the reply FIFO is non-empty. All other bits read 0.
- R7: Offset 0x34 holds a disable bit at bit 3. It resets to 1. A write loads it from bit 3 of the data, so writing 0 enables the interrupt. The register reads back with the disable bit at bit 3. `irq_o` is high exactly when replies are pending and the disable bit is 0.
- R8: With `ALT_BIT`=1, bit 2 replaces bit 3 for both the disable bit and the pending bit. Bit 3 is then ignored on mask writes.
- R9: Offset 0xB0 reads 0 until `READY_DLY` clock edges have passed since reset release, and reads 0xFFFF0000 from then on.
- R10: A write to offset 0x20 stores the data. It reads back at 0x20 and drives `doorbell_o`.
- R11: After reset both FIFOs are empty, `irq_o`, `req_valid_o`, `ovf_o` and `rpl_full_o` are low, and `rdata_o` is 0 when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Host interrupt |
| req_valid_o | output | 1 | Request FIFO non-empty |
| req_data_o | output | 32 | Oldest request |
| req_pop_i | input | 1 | Engine removes the oldest request |
| rpl_push_i | input | 1 | Engine pushes a reply |
| rpl_data_i | input | 32 | Reply tag |
| rpl_err_i | input | 1 | Reply carries an error |
| rpl_full_o | output | 1 | Reply FIFO full |
| doorbell_o | output | 32 | Doorbell register value |
| ovf_o | output | 1 | Sticky request overflow |

## Verification
The bench pushes the request FIFO one entry past its depth. A design that accepted the 17th write would corrupt the oldest entry or lose `ovf_o`. It reads the empty reply port repeatedly. A design that popped on empty would return stale data or wrap its pointers, so later replies would come back out of order. It sets the disable bit while replies are pending, and it pushes and pops on the same cycle when the FIFO is full. Getting the mask polarity wrong would leave the interrupt stuck on or stuck off, and a full-FIFO push that slipped through would overwrite the head. A second instance built with the alternate bit shows whether bit 3 is really ignored in that variant.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [7:0]  OFS_DOORBELL = 8'h20;
  localparam logic [7:0]  OFS_STATUS   = 8'h30;
  localparam logic [7:0]  OFS_MASK     = 8'h34;
  localparam logic [7:0]  OFS_REQ      = 8'h40;
  localparam logic [7:0]  OFS_RPL      = 8'h44;
  localparam logic [7:0]  OFS_SCRATCH  = 8'hB0;
  localparam logic [31:0] RPL_EMPTY    = 32'hFFFF_FFFF;
  localparam logic [31:0] READY_WORD   = 32'hFFFF_0000;
  localparam int          ERR_POS      = 1;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty_o = (count_o == '0);
  assign full_o  = (count_o == CW'(DEPTH));
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr    <= '0;
      rptr    <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      if (do_push && !do_pop)      count_o <= count_o + 1'b1;
      else if (do_pop && !do_push) count_o <= count_o - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr] <= data_i;
  end
endmodule

// File: rtl/mbx_ready_timer.sv
module mbx_ready_timer #(
  parameter int DLY = 32,
  localparam int CW = $clog2(DLY + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  logic [CW-1:0] cnt;

  assign ready_o = (cnt == CW'(DLY));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt <= '0;
    else if (!ready_o) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter bit ALT_BIT   = 1'b0,
  parameter int READY_DLY = 32,
  localparam int IB       = ALT_BIT ? 2 : 3,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        req_valid_o,
  output logic [31:0] req_data_o,
  input  logic        req_pop_i,
  input  logic        rpl_push_i,
  input  logic [31:0] rpl_data_i,
  input  logic        rpl_err_i,
  output logic        rpl_full_o,
  output logic [31:0] doorbell_o,
  output logic        ovf_o
);
  logic          req_wr, req_full, req_empty;
  logic          rpl_rd, rpl_empty, ready;
  logic [31:0]   rpl_head, rpl_word;
  logic [CW-1:0] req_cnt, rpl_cnt;
  logic          mask_off;

  assign req_wr      = wr_en_i && (addr_i == OFS_REQ);
  assign rpl_rd      = rd_en_i && (addr_i == OFS_RPL);
  assign req_valid_o = ~req_empty;
  assign rpl_word    = rpl_data_i | (32'(rpl_err_i) << ERR_POS);
  assign irq_o       = ~rpl_empty & ~mask_off;

  mbx_fifo #(.DW(32), .DEPTH(DEPTH)) u_req_fifo (
    .clk_i, .rst_ni,
    .push_i (req_wr),
    .data_i (wdata_i),
    .pop_i  (req_pop_i),
    .data_o (req_data_o),
    .empty_o(req_empty),
    .full_o (req_full),
    .count_o(req_cnt)
  );

  mbx_fifo #(.DW(32), .DEPTH(DEPTH)) u_rpl_fifo (
    .clk_i, .rst_ni,
    .push_i (rpl_push_i),
    .data_i (rpl_word),
    .pop_i  (rpl_rd),
    .data_o (rpl_head),
    .empty_o(rpl_empty),
    .full_o (rpl_full_o),
    .count_o(rpl_cnt)
  );

  mbx_ready_timer #(.DLY(READY_DLY)) u_ready (
    .clk_i, .rst_ni,
    .ready_o(ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_off   <= 1'b1;
      doorbell_o <= '0;
      ovf_o      <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == OFS_MASK)     mask_off   <= wdata_i[IB];
      if (wr_en_i && addr_i == OFS_DOORBELL) doorbell_o <= wdata_i;
      if (req_wr && req_full)                ovf_o      <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        OFS_DOORBELL: rdata_o = doorbell_o;
        OFS_STATUS:   rdata_o[IB] = ~rpl_empty;
        OFS_MASK:     rdata_o[IB] = mask_off;
        OFS_RPL:      rdata_o = rpl_empty ? RPL_EMPTY : rpl_head;
        OFS_SCRATCH:  rdata_o = ready ? READY_WORD : '0;
        default:      rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [7:0]    addr_i,
  input logic [31:0]   rdata_o,
  input logic          irq_o,
  input logic          ovf_o,
  input logic          req_pop_i,
  input logic          rpl_push_i,
  input logic [CW-1:0] req_cnt,
  input logic [CW-1:0] rpl_cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(req_cnt) <= DEPTH && int'(rpl_cnt) <= DEPTH); // R2

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R2

  AST_REQ_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_REQ && int'(req_cnt) < DEPTH && !req_pop_i)
    |=> int'(req_cnt) == int'($past(req_cnt)) + 1); // R1

  AST_EMPTY_SENTINEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_RPL && rpl_cnt == '0) |-> rdata_o == RPL_EMPTY); // R4

  AST_EMPTY_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_RPL && rpl_cnt == '0 && !rpl_push_i) |=> rpl_cnt == '0); // R4

  AST_IRQ_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rpl_cnt != '0); // R7
endmodule

bind cmd_mailbox mbx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .rdata_o, .irq_o, .ovf_o,
  .req_pop_i, .rpl_push_i, .req_cnt(req_cnt), .rpl_cnt(rpl_cnt)
);

// File: tb/tb_cmd_mailbox.sv
module tb_cmd_mailbox;
  localparam int DLY = 24;
  localparam int DEP = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic        wr, rd, pop, push, perr;
  logic [7:0]  ad;
  logic [31:0] wd, pd, rdata, req_data, db;
  logic        irq, req_valid, rfull, ovf;

  cmd_mailbox #(.DEPTH(DEP), .READY_DLY(DLY)) dut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr), .rd_en_i(rd), .addr_i(ad), .wdata_i(wd),
    .rdata_o(rdata), .irq_o(irq), .req_valid_o(req_valid), .req_data_o(req_data),
    .req_pop_i(pop), .rpl_push_i(push), .rpl_data_i(pd), .rpl_err_i(perr),
    .rpl_full_o(rfull), .doorbell_o(db), .ovf_o(ovf)
  );

  logic        a_wr, a_rd, a_push;
  logic [7:0]  a_ad;
  logic [31:0] a_wd, a_rdata, a_req_data, a_db;
  logic        a_irq, a_req_valid, a_rfull, a_ovf;

  cmd_mailbox #(.DEPTH(DEP), .ALT_BIT(1'b1), .READY_DLY(DLY)) dut_alt (
    .clk_i(clk), .rst_ni, .wr_en_i(a_wr), .rd_en_i(a_rd), .addr_i(a_ad), .wdata_i(a_wd),
    .rdata_o(a_rdata), .irq_o(a_irq), .req_valid_o(a_req_valid), .req_data_o(a_req_data),
    .req_pop_i(1'b0), .rpl_push_i(a_push), .rpl_data_i(32'h10), .rpl_err_i(1'b0),
    .rpl_full_o(a_rfull), .doorbell_o(a_db), .ovf_o(a_ovf)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [31:0] req_q[$], rpl_q[$];
  bit          m_mask = 1'b1, m_ovf = 1'b0;
  logic [31:0] m_db = '0;
  int          mcyc = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d,
                      input bit p, input bit ps, input logic [31:0] pdat, input bit pe);
    logic [31:0] exp;
    string tag;
    bit wok, rpl_nonempty, rpl_room;
    @(negedge clk);
    wr = w; rd = r; ad = a; wd = d; pop = p; push = ps; pd = pdat; perr = pe;
    #5;
    if (r) begin
      exp = '0; tag = "R11";
      case (a)
        8'h20: begin exp = m_db; tag = "R10"; end
        8'h30: begin exp = (rpl_q.size() != 0) ? 32'h8 : 32'h0; tag = "R6"; end
        8'h34: begin exp = m_mask ? 32'h8 : 32'h0; tag = "R7"; end
        8'h44: begin
          if (rpl_q.size() != 0) begin exp = rpl_q[0]; tag = "R3/R5"; end
          else begin exp = 32'hFFFF_FFFF; tag = "R4"; end
        end
        8'hB0: begin exp = (mcyc >= DLY) ? 32'hFFFF_0000 : 32'h0; tag = "R9"; end
        default: ;
      endcase
      check(tag, rdata, exp);
    end
    check("R7 irq", 32'(irq), 32'((rpl_q.size() != 0) && !m_mask));
    check("R1 valid", 32'(req_valid), 32'(req_q.size() != 0));
    if (req_q.size() != 0) check("R1 data", req_data, req_q[0]);
    check("R2 ovf", 32'(ovf), 32'(m_ovf));
    check("R10 doorbell", db, m_db);
    check("R3 full", 32'(rfull), 32'(rpl_q.size() == DEP));
    @(posedge clk);
    wok = req_q.size() < DEP;
    rpl_nonempty = rpl_q.size() != 0;
    rpl_room = rpl_q.size() < DEP;
    if (p && req_q.size() != 0) void'(req_q.pop_front());
    if (w && a == 8'h40) begin
      if (wok) req_q.push_back(d); else m_ovf = 1'b1;
    end
    if (w && a == 8'h34) m_mask = d[3];
    if (w && a == 8'h20) m_db = d;
    if (r && a == 8'h44 && rpl_nonempty) void'(rpl_q.pop_front());
    if (ps && rpl_room) rpl_q.push_back(pdat | (pe ? 32'h2 : 32'h0));
    mcyc++;
  endtask

  task automatic idle();
    step(0, 0, 8'h0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    if (!done) begin
      $display("%0d/%0d checks passed", nchk - nfail + 1, nchk + 1);
      $finish;
    end
  end

  initial begin
    wr = 0; rd = 0; ad = 0; wd = 0; pop = 0; push = 0; pd = 0; perr = 0;
    a_wr = 0; a_rd = 0; a_push = 0; a_ad = 0; a_wd = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 irq", 32'(irq), 0);
    check("R11 valid", 32'(req_valid), 0);
    check("R11 ovf", 32'(ovf), 0);
    check("R11 full", 32'(rfull), 0);
    check("R11 rdata", rdata, 0);
    rst_ni = 1'b1;
    @(posedge clk);
    mcyc = 1;

    step(0, 1, 8'hB0, 0, 0, 0, 0, 0);           // R9 not ready yet
    step(0, 1, 8'h34, 0, 0, 0, 0, 0);           // R7 reset mask
    step(1, 0, 8'h34, 0, 0, 0, 0, 0);           // R7 enable
    step(0, 1, 8'h30, 0, 0, 0, 0, 0);           // R6 idle status
    step(0, 0, 8'h0, 0, 0, 1, 32'h1000, 0);
    step(0, 0, 8'h0, 0, 0, 1, 32'h2004, 1);     // R5 error tag
    step(0, 0, 8'h0, 0, 0, 1, 32'h3008, 0);
    step(0, 1, 8'h30, 0, 0, 0, 0, 0);           // R6 pending
    for (int i = 0; i < 5; i++) step(0, 1, 8'h44, 0, 0, 0, 0, 0); // R3, R4
    check("R4 empty status", 32'(irq), 0);

    for (int i = 0; i < 17; i++) step(1, 0, 8'h40, 32'hA000 + i, 0, 0, 0, 0); // R2
    step(1, 0, 8'h40, 32'hBEEF, 1, 0, 0, 0);    // R2 full, pop same cycle
    for (int i = 0; i < 17; i++) step(0, 0, 8'h0, 0, 1, 0, 0, 0);          // R1 drain
    step(1, 0, 8'h40, 32'hC001, 1, 0, 0, 0);    // R1 push + pop on empty
    step(1, 0, 8'h40, 32'hC002, 1, 0, 0, 0);
    idle();

    step(1, 0, 8'h20, 32'h5A5A_00FF, 0, 0, 0, 0); // R10
    step(0, 1, 8'h20, 0, 0, 0, 0, 0);

    for (int i = 0; i < 17; i++) step(0, 0, 8'h0, 0, 0, 1, 32'h100 * i, i[0]); // R3 full
    step(0, 1, 8'h44, 0, 0, 1, 32'hDEAD0, 0);   // R3 push+pop while full
    step(1, 0, 8'h34, 32'h8, 0, 0, 0, 0);       // R7 disable while pending
    step(0, 1, 8'h34, 0, 0, 0, 0, 0);
    step(1, 0, 8'h34, 32'hFFFF_FFF7, 0, 0, 0, 0); // R7 bit 3 clear enables
    for (int i = 0; i < 17; i++) step(0, 1, 8'h44, 0, 0, 0, 0, 0);

    while (mcyc < DLY + 2) idle();
    step(0, 1, 8'hB0, 0, 0, 0, 0, 0);           // R9 ready

    // R8 alternate bit variant
    @(negedge clk); a_push = 1;
    @(negedge clk); a_push = 0; a_rd = 1; a_ad = 8'h30; #5;
    check("R8 alt status", a_rdata, 32'h4);
    check("R8 alt irq masked", 32'(a_irq), 0);
    @(negedge clk); a_rd = 0; a_wr = 1; a_ad = 8'h34; a_wd = 32'h0;
    @(negedge clk); a_wr = 1; a_wd = 32'h8; #5;
    check("R8 alt irq on", 32'(a_irq), 1);
    @(negedge clk); a_wr = 0; #5;
    check("R8 alt bit3 ignored", 32'(a_irq), 1);
    a_wr = 1; a_wd = 32'h4;
    @(negedge clk); a_wr = 0; a_rd = 1; #5;
    check("R8 alt irq off", 32'(a_irq), 0);
    check("R8 alt mask read", a_rdata, 32'h4);
    @(negedge clk); a_rd = 0;

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule